// File: doc/BRIEF.md
# Toggle-Write Random Access Scan Array

A square grid of state bits that serve the surrounding logic as ordinary registers in functional mode and can be reached one bit at a time in test mode. In functional mode every bit takes its next-state input on each clock edge. In test mode the functional capture is switched off and a single bit, chosen by a registered binary address split into a row field and a column field, can be inverted. A bit changes only when both its row line and its column line are active. Every other bit keeps its value. No bit has a serial scan input or a per-bit test-control wire.

The addressed bit is always driven onto a registered read-out output, so test equipment can observe any bit without shifting. A built-in write sequencer sets an addressed bit to a requested value. It reads the bit, compares it with the target, and issues one toggle only when the two differ. This gives load-by-value behaviour on top of the toggle-only storage.

Top module: `tras_array`

## Requirements
- R1: While `rst_n` is low, all bits of `state_q` are 0, `rd_data` is 0, `busy` is 0 and the stored address is 0.
- R2: While `test_en` is 0, every bit of `state_q` takes the value of the matching bit of `func_d` at each rising clock edge.
- R3: While `test_en` is 1 and no toggle strobe is pending, `state_q` holds and `func_d` has no effect.
- R4: `addr_ld` with `busy` low stores `addr` at the clock edge. The upper half of `addr` selects the row and the lower half selects the column. The addressed bit is `state_q[row*SIDE+col]`.
- R5: `tgl` sampled high at edge k, with `test_en` high and `busy` low, inverts the addressed bit at edge k+1. Every other bit holds.
- R6: When `addr_ld` and `tgl` are sampled at the same edge, the toggle lands on the newly loaded address.
- R7: At most one row line and at most one column line are active at any time. No line is active while `test_en` is 0.
- R8: After each edge, `rd_data` equals the addressed bit as it stood just before that edge.
- R9: `wr_req` sampled at edge k (with `test_en` high, `busy` low and `tgl` low) raises `busy` from edge k. If the addressed bit differs from `wr_val`, the bit inverts at edge k+3 and `busy` is low after edge k+3. Otherwise no bit changes and `busy` is low after edge k+2.
- R10: While `busy` is high, `tgl`, `addr_ld` and `wr_req` are ignored. When `tgl` and `wr_req` arrive together while the block is idle, the toggle is performed and the write is dropped.
- R11: While `test_en` is 0, `tgl` and `wr_req` are ignored. A write in progress is abandoned. A toggle strobe still pending when `test_en` falls is dropped, and functional capture takes effect instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all bits and control |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en | input | 1 | 1 = test access, 0 = functional capture |
| func_d | input | SIDE*SIDE | Functional next-state data, one bit per cell |
| state_q | output | SIDE*SIDE | Stored cell values |
| addr | input | 2*log2(SIDE) | Cell address, row field in the upper half |
| addr_ld | input | 1 | Load `addr` into the address register |
| tgl | input | 1 | Request a toggle of the addressed cell |
| wr_req | input | 1 | Start a read-compare-toggle write |
| wr_val | input | 1 | Target value for the write |
| busy | output | 1 | Write sequence in progress |
| rd_data | output | 1 | Registered value of the addressed cell |

## Verification
Two pairs of operations can meet in one cycle. The first pair is an address load and a toggle request. The bench issues both on the same edge and checks that only the bit at the new address inverts, one edge later. The second pair is a pending toggle strobe and the drop of `test_en`. The bench raises `tgl`, then lowers `test_en` before the strobe can act. It judges the result by comparing the whole `state_q` word against `func_d`, so any stray inversion would show. The bench also fires `tgl` and `wr_req` together and checks that the toggle wins and `busy` stays low.

// File: rtl/tras_pkg.sv
package tras_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_READ = 2'd1,
      SQ_CMP  = 2'd2,
      SQ_FLIP = 2'd3
   } sq_state_t;
endpackage

// File: rtl/tras_decoder.sv
module tras_decoder #(
   parameter int LINES = 4,
   localparam int SW = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic [SW-1:0]    sel,
   input  logic             en,
   output logic [LINES-1:0] line
);
   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign line[i] = en && (sel == SW'(i));
   end
endmodule

// File: rtl/tras_cell.sv
module tras_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic cap,
   input  logic d,
   input  logic row_hit,
   input  logic col_hit,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= 1'b0;
      else if (cap)              q <= d;
      else if (row_hit && col_hit) q <= ~q;
   end
endmodule

// File: rtl/tras_wr_seq.sv
module tras_wr_seq
   import tras_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic test_en,
   input  logic wr_req,
   input  logic wr_val,
   input  logic tgl,
   input  logic rd_bit,
   output logic busy,
   output logic flip_req
);
   sq_state_t st;
   logic      tgt;

   assign busy     = (st != SQ_IDLE);
   assign flip_req = test_en && (st == SQ_CMP) && (rd_bit != tgt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= SQ_IDLE;
         tgt <= 1'b0;
      end else if (!test_en) begin
         st  <= SQ_IDLE;
      end else begin
         unique case (st)
            SQ_IDLE: if (wr_req && !tgl) begin
               st  <= SQ_READ;
               tgt <= wr_val;
            end
            SQ_READ: st <= SQ_CMP;
            SQ_CMP:  st <= (rd_bit != tgt) ? SQ_FLIP : SQ_IDLE;
            SQ_FLIP: st <= SQ_IDLE;
            default: st <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tras_array.sv
module tras_array #(
   parameter int SIDE = 4,
   localparam int HW = $clog2(SIDE),
   localparam int AW = 2 * HW,
   localparam int N  = SIDE * SIDE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          test_en,
   input  logic [N-1:0]  func_d,
   output logic [N-1:0]  state_q,
   input  logic [AW-1:0] addr,
   input  logic          addr_ld,
   input  logic          tgl,
   input  logic          wr_req,
   input  logic          wr_val,
   output logic          busy,
   output logic          rd_data
);
   if (SIDE < 2 || (SIDE & (SIDE - 1)) != 0) begin : g_bad_side
      $error("tras_array: SIDE must be a power of two of at least 2");
   end

   logic [AW-1:0]   addr_q;
   logic            strobe_q;
   logic            flip_req;
   logic            dec_en;
   logic [SIDE-1:0] row_line;
   logic [SIDE-1:0] col_line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         strobe_q <= 1'b0;
         rd_data  <= 1'b0;
      end else begin
         if (addr_ld && !busy) addr_q <= addr;
         strobe_q <= test_en && ((tgl && !busy) || flip_req);
         rd_data  <= state_q[addr_q];
      end
   end

   assign dec_en = strobe_q && test_en;

   tras_decoder #(.LINES(SIDE)) u_row_dec (
      .sel  (addr_q[AW-1:HW]),
      .en   (dec_en),
      .line (row_line)
   );

   tras_decoder #(.LINES(SIDE)) u_col_dec (
      .sel  (addr_q[HW-1:0]),
      .en   (dec_en),
      .line (col_line)
   );

   for (genvar r = 0; r < SIDE; r++) begin : g_row
      for (genvar c = 0; c < SIDE; c++) begin : g_col
         tras_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap     (!test_en),
            .d       (func_d[r*SIDE+c]),
            .row_hit (row_line[r]),
            .col_hit (col_line[c]),
            .q       (state_q[r*SIDE+c])
         );
      end
   end

   tras_wr_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .test_en  (test_en),
      .wr_req   (wr_req),
      .wr_val   (wr_val),
      .tgl      (tgl),
      .rd_bit   (rd_data),
      .busy     (busy),
      .flip_req (flip_req)
   );
endmodule

// File: rtl/tras_array_chk.sv
module tras_array_chk #(
   parameter int SIDE = 4,
   localparam int HW = $clog2(SIDE),
   localparam int AW = 2 * HW,
   localparam int N  = SIDE * SIDE
) (
   input logic            clk,
   input logic            rst_n,
   input logic            test_en,
   input logic [N-1:0]    func_d,
   input logic [N-1:0]    state_q,
   input logic            addr_ld,
   input logic            busy,
   input logic            rd_data,
   input logic [AW-1:0]   addr_q,
   input logic            strobe_q,
   input logic [SIDE-1:0] row_line,
   input logic [SIDE-1:0] col_line
);
   logic sel_bit;
   assign sel_bit = state_q[int'(addr_q[AW-1:HW]) * SIDE + int'(addr_q[HW-1:0])];

   p_func_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !test_en |=> state_q == $past(func_d));

   p_test_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && !strobe_q) |=> $stable(state_q));

   p_single_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && strobe_q) |=> $countones(state_q ^ $past(state_q)) == 1);

   p_lines_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_line) && $onehot0(col_line));

   p_lines_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !test_en |-> (row_line == '0 && col_line == '0));

   p_readout_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> rd_data == $past(sel_bit));

   p_addr_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && addr_ld) |=> $stable(addr_q));

   p_idle_out_test_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !test_en |=> !busy);
endmodule

bind tras_array tras_array_chk #(.SIDE(SIDE)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .test_en  (test_en),
   .func_d   (func_d),
   .state_q  (state_q),
   .addr_ld  (addr_ld),
   .busy     (busy),
   .rd_data  (rd_data),
   .addr_q   (addr_q),
   .strobe_q (strobe_q),
   .row_line (row_line),
   .col_line (col_line)
);

// File: tb/tras_array_tb.sv
`timescale 1ns/1ps
module tras_array_tb;
   localparam int SIDE = 4;
   localparam int HW = $clog2(SIDE);
   localparam int AW = 2 * HW;
   localparam int N  = SIDE * SIDE;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          test_en = 1'b0;
   logic [N-1:0]  func_d = '0;
   logic [N-1:0]  state_q;
   logic [AW-1:0] addr = '0;
   logic          addr_ld = 1'b0;
   logic          tgl = 1'b0;
   logic          wr_req = 1'b0;
   logic          wr_val = 1'b0;
   logic          busy;
   logic          rd_data;

   logic [N-1:0]  model = '0;
   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   tras_array #(.SIDE(SIDE)) u_dut (
      .clk(clk), .rst_n(rst_n), .test_en(test_en), .func_d(func_d),
      .state_q(state_q), .addr(addr), .addr_ld(addr_ld), .tgl(tgl),
      .wr_req(wr_req), .wr_val(wr_val), .busy(busy), .rd_data(rd_data)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] mk_addr(input int row, input int col);
      return AW'(row * SIDE + col);
   endfunction

   task automatic load_addr(input int row, input int col);
      addr = mk_addr(row, col); addr_ld = 1'b1;
      tick();
      addr_ld = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      #12;
      check("R1 state", 64'(state_q), 64'(0));
      check("R1 rd_data", 64'(rd_data), 64'(0));
      check("R1 busy", 64'(busy), 64'(0));
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      tick();
      check("R1 address zero via readout", 64'(rd_data), 64'(0));
   endtask

   task automatic t_func();
      test_en = 1'b0;
      func_d = 16'hA5C3; tick();
      check("R2 capture 1", 64'(state_q), 64'h A5C3);
      func_d = 16'h5A0F; tick();
      check("R2 capture 2", 64'(state_q), 64'h5A0F);
      model = 16'h5A0F;
   endtask

   task automatic t_hold();
      test_en = 1'b1;
      func_d = 16'hFFFF;
      tick(); tick(); tick();
      check("R3 hold, func_d ignored", 64'(state_q), 64'(model));
   endtask

   task automatic t_toggle(input int row, input int col);
      int idx = row * SIDE + col;
      load_addr(row, col);
      tgl = 1'b1; tick(); tgl = 1'b0;
      check("R5 no change at strobe edge", 64'(state_q), 64'(model));
      tick();
      model[idx] = ~model[idx];
      check("R5 R7 R4 single addressed flip", 64'(state_q), 64'(model));
      tick();
      check("R8 readout after toggle", 64'(rd_data), 64'(model[idx]));
   endtask

   task automatic t_same_cycle();
      addr = mk_addr(3, 2); addr_ld = 1'b1; tgl = 1'b1;
      tick();
      addr_ld = 1'b0; tgl = 1'b0;
      tick();
      model[14] = ~model[14];
      check("R6 toggle on new address", 64'(state_q), 64'(model));
   endtask

   task automatic t_read();
      load_addr(1, 0);
      tick();
      check("R8 read idx4", 64'(rd_data), 64'(model[4]));
      load_addr(0, 0);
      tick();
      check("R8 read idx0", 64'(rd_data), 64'(model[0]));
   endtask

   task automatic t_write(input int row, input int col, input logic val);
      int idx = row * SIDE + col;
      logic differ;
      load_addr(row, col);
      differ = (model[idx] != val);
      wr_val = val; wr_req = 1'b1;
      tick();
      wr_req = 1'b0;
      check("R9 busy after request", 64'(busy), 64'(1));
      tick();
      tick();
      check("R9 no change before flip", 64'(state_q), 64'(model));
      if (differ) begin
         check("R9 busy while flipping", 64'(busy), 64'(1));
         tick();
         model[idx] = val;
         check("R9 bit written", 64'(state_q), 64'(model));
      end
      check("R9 busy low at end", 64'(busy), 64'(0));
   endtask

   task automatic t_busy_ignore();
      load_addr(1, 1);
      wr_val = ~model[5]; wr_req = 1'b1;
      tick();
      wr_req = 1'b0;
      tgl = 1'b1; addr_ld = 1'b1; addr = mk_addr(0, 0);
      tick();
      tgl = 1'b0; addr_ld = 1'b0;
      tick(); tick();
      model[5] = ~model[5];
      check("R10 only write applied", 64'(state_q), 64'(model));
      check("R10 busy done", 64'(busy), 64'(0));
      tick();
      check("R10 address kept", 64'(rd_data), 64'(model[5]));
      tgl = 1'b1; wr_req = 1'b1; wr_val = model[5];
      tick();
      tgl = 1'b0; wr_req = 1'b0;
      check("R10 write dropped with toggle", 64'(busy), 64'(0));
      tick();
      model[5] = ~model[5];
      check("R10 toggle wins", 64'(state_q), 64'(model));
   endtask

   task automatic t_exit();
      load_addr(2, 2);
      tgl = 1'b1; tick(); tgl = 1'b0;
      test_en = 1'b0; func_d = 16'h3C96;
      tick();
      model = 16'h3C96;
      check("R11 capture beats pending strobe", 64'(state_q), 64'(model));
      tgl = 1'b1; wr_req = 1'b1; wr_val = 1'b0;
      tick();
      check("R11 write ignored", 64'(busy), 64'(0));
      test_en = 1'b1; tgl = 1'b0; wr_req = 1'b0;
      tick(); tick();
      check("R11 toggle ignored", 64'(state_q), 64'(model));
      load_addr(2, 2);
      wr_val = ~model[10]; wr_req = 1'b1;
      tick();
      wr_req = 1'b0; test_en = 1'b0; func_d = 16'h0F0F;
      tick();
      check("R11 write abandoned", 64'(busy), 64'(0));
      test_en = 1'b1;
      tick(); tick(); tick();
      model = 16'h0F0F;
      check("R11 no late flip", 64'(state_q), 64'(model));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_func();
      t_hold();
      t_toggle(2, 1);
      t_toggle(0, 3);
      t_same_cycle();
      t_read();
      t_write(1, 1, ~model[5]);
      t_write(1, 1, model[5]);
      t_busy_ignore();
      t_exit();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule